// File: doc/BRIEF.md
# Multi-Lane Serial ADC Word Deserializer with Frame Training

This block sits behind the differential receivers of a multi-channel serial ADC. It turns each serial lane into parallel sample words. The bit clock runs at six times the frame rate, and every lane is sampled on both of its edges, so one frame holds twelve bits. Each bit-clock edge delivers one bit per lane.

The falling-edge sample is captured on the falling edge and then registered again on the next rising edge. From that point, the pair (rising sample first, falling sample second) is shifted into a per-lane history register in the rising-edge domain. The bits enter MSB first, two per cycle. Every six cycles a 12-bit window is taken from each history register.

The frame clock is not used as a clock. It goes through a lane of its own, with the same capture logic as the samples, and acts as a training pattern. A controller checks the deserialized frame word. When the word is not six zeros followed by six ones, the controller moves the window offset by one bit position. The same offset applies to every lane, so the sample words line up with their frames once the frame word is correct.

Top module: `adc_frame_deser`

## Requirements
- R1: `wordValid` is a single-cycle pulse that recurs exactly every six clock cycles.
- R2: Within each bit-clock cycle, the bit present at the rising edge is the more significant of the pair, and the bit present at the following falling edge is the next bit down. Words are assembled MSB first. Once locked, every `dataWords` lane equals the 12-bit word that was sent in one frame, with consecutive valid words coming from consecutive frames.
- R3: The frame lane uses the same capture and windowing as the data lanes. While the block is locked, `frameWord` reads 12'h03F (bits 11..6 zero, bits 5..0 one).
- R4: One window offset is shared by all lanes. From any phase of the incoming stream, the block reaches lock within 50 word periods, and all data lanes are then frame-aligned together.
- R5: `locked` rises only after at least three consecutive judged frame words equal 12'h03F.
- R6: While locked, a frame word other than 12'h03F clears `locked` on the next clock edge and restarts the search with a one-position slip.
- R7: The window offset steps through 0..11 and wraps from 11 back to 0, so a phase shift of the stream in either direction is recovered.
- R8: A synchronous `rst` clears the history registers, the window offset, the word counter, the output words and `locked`. During reset `wordValid` stays low.
- R9: After each slip, the next two frame words are ignored. Two slips are therefore always at least three word periods apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; both edges sample the lanes |
| rst | input | 1 | Synchronous reset, active high |
| frameIn | input | 1 | Frame clock, received as a serial lane |
| dataIn | input | DATA_LANES | Serial sample lanes, one bit per lane |
| dataWords | output | DATA_LANES*WORD_W | Parallel word per data lane, lane 0 in the low bits |
| frameWord | output | WORD_W | Deserialized frame lane word |
| wordValid | output | 1 | Pulses when new words are presented |
| locked | output | 1 | Word alignment reached |

## Verification
The bench builds the block with three data lanes, 12-bit words, a lock count of three and a settle time of two words. At these settings a full slip search is a few hundred cycles long. This makes it practical to start the stream at several phases and to inject one-bit phase shifts in both directions, which forces the window offset to wrap from 11 to 0. Each data word sent carries its own frame number, so after every relock the scoreboard can show that all lanes moved together and that no frame was dropped or repeated.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

  // Strobes from the alignment controller to the lane datapath.
  typedef struct packed {
    logic slipStep;   // advance the shared window offset by one bit
  } deser_ctrl_t;

endpackage

// File: rtl/adc_deser_path.sv
module adc_deser_path
  import adc_deser_pkg::*;
#(
  parameter int NUM_LANES = 5,
  parameter int WORD_W    = 12
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_LANES-1:0]               laneIn,
  input  deser_ctrl_t                        ctrl,
  output logic [NUM_LANES-1:0][WORD_W-1:0]   laneWords,
  output logic                               wordValid
);
  localparam int PAIRS  = WORD_W / 2;
  localparam int HIST_W = 2 * WORD_W;
  localparam int CNT_W  = $clog2(PAIRS);
  localparam int POS_W  = $clog2(WORD_W);

  logic [NUM_LANES-1:0] riseCap;
  logic [NUM_LANES-1:0] fallCap;
  logic [CNT_W-1:0]     pairCnt;
  logic [POS_W-1:0]     slipPos;
  logic                 wordDue;

  // Falling-edge capture; re-registered into the rising domain by the history shift.
  always_ff @(negedge clk) begin
    if (rst) fallCap <= '0;
    else     fallCap <= laneIn;
  end

  always_ff @(posedge clk) begin
    if (rst) riseCap <= '0;
    else     riseCap <= laneIn;
  end

  assign wordDue = (pairCnt == CNT_W'(PAIRS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pairCnt   <= '0;
      wordValid <= 1'b0;
    end else begin
      pairCnt   <= wordDue ? '0 : pairCnt + 1'b1;
      wordValid <= wordDue;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slipPos <= '0;
    end else if (ctrl.slipStep) begin
      slipPos <= (slipPos == POS_W'(WORD_W - 1)) ? '0 : slipPos + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [HIST_W-1:0] hist;
    logic [WORD_W-1:0] wordWin;
    logic [WORD_W-1:0] wordQ;

    always_ff @(posedge clk) begin
      if (rst) hist <= '0;
      else     hist <= {hist[HIST_W-3:0], riseCap[g], fallCap[g]};
    end

    assign wordWin = WORD_W'(hist >> slipPos);

    always_ff @(posedge clk) begin
      if (rst)          wordQ <= '0;
      else if (wordDue) wordQ <= wordWin;
    end

    assign laneWords[g] = wordQ;
  end

  p_valid_gap_r1: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  p_slip_range_r7: assert property (@(posedge clk) disable iff (rst)
    slipPos <= POS_W'(WORD_W - 1));

  p_slip_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.slipStep && slipPos == POS_W'(WORD_W - 1)) |=> (slipPos == '0));

endmodule

// File: rtl/adc_deser_ctrl.sv
module adc_deser_ctrl
  import adc_deser_pkg::*;
#(
  parameter int                WORD_W        = 12,
  parameter logic [WORD_W-1:0] FRAME_PATTERN = 12'h03F,
  parameter int                LOCK_COUNT    = 3,
  parameter int                SETTLE_WORDS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] frameWord,
  input  logic              wordValid,
  output deser_ctrl_t       ctrl,
  output logic              locked
);
  localparam int MATCH_W = $clog2(LOCK_COUNT + 1);
  localparam int SET_W   = $clog2(SETTLE_WORDS + 1);

  logic [MATCH_W-1:0] matchCnt;
  logic [SET_W-1:0]   settleCnt;
  logic               frameHit;
  logic               judge;

  assign frameHit      = (frameWord == FRAME_PATTERN);
  assign judge         = wordValid && (settleCnt == '0);
  assign ctrl.slipStep = judge && !frameHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      matchCnt  <= '0;
      settleCnt <= '0;
      locked    <= 1'b0;
    end else if (wordValid) begin
      if (settleCnt != '0) begin
        settleCnt <= settleCnt - 1'b1;
      end else if (frameHit) begin
        if (matchCnt >= MATCH_W'(LOCK_COUNT - 1)) locked <= 1'b1;
        else                                       matchCnt <= matchCnt + 1'b1;
      end else begin
        matchCnt  <= '0;
        locked    <= 1'b0;
        settleCnt <= SET_W'(SETTLE_WORDS);
      end
    end
  end

  // Checker state: words seen since the last slip, saturating.
  logic [SET_W-1:0] sinceSlip;
  always_ff @(posedge clk) begin
    if (rst)                  sinceSlip <= SET_W'(SETTLE_WORDS);
    else if (ctrl.slipStep)   sinceSlip <= '0;
    else if (wordValid && sinceSlip < SET_W'(SETTLE_WORDS))
                              sinceSlip <= sinceSlip + 1'b1;
  end

  p_lock_on_hit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(wordValid && frameWord == FRAME_PATTERN));

  p_unlock_on_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (locked && wordValid && frameWord != FRAME_PATTERN) |=> !locked);

  p_slip_unlocks_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl.slipStep |=> !locked);

  p_settle_gap_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl.slipStep |-> (sinceSlip == SET_W'(SETTLE_WORDS)));

endmodule

// File: rtl/adc_frame_deser.sv
module adc_frame_deser
  import adc_deser_pkg::*;
#(
  parameter int                DATA_LANES    = 4,
  parameter int                WORD_W        = 12,
  parameter int                LOCK_COUNT    = 3,
  parameter int                SETTLE_WORDS  = 2,
  parameter logic [WORD_W-1:0] FRAME_PATTERN = {{(WORD_W/2){1'b0}}, {(WORD_W/2){1'b1}}}
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 frameIn,
  input  logic [DATA_LANES-1:0]                dataIn,
  output logic [DATA_LANES-1:0][WORD_W-1:0]    dataWords,
  output logic [WORD_W-1:0]                    frameWord,
  output logic                                 wordValid,
  output logic                                 locked
);
  localparam int NUM_LANES = DATA_LANES + 1;

  logic [NUM_LANES-1:0]             laneIn;
  logic [NUM_LANES-1:0][WORD_W-1:0] laneWords;
  deser_ctrl_t                      ctrl;

  assign laneIn    = {dataIn, frameIn};
  assign frameWord = laneWords[0];
  assign dataWords = laneWords[NUM_LANES-1:1];

  adc_deser_path #(
    .NUM_LANES (NUM_LANES),
    .WORD_W    (WORD_W)
  ) path_i (
    .clk       (clk),
    .rst       (rst),
    .laneIn    (laneIn),
    .ctrl      (ctrl),
    .laneWords (laneWords),
    .wordValid (wordValid)
  );

  adc_deser_ctrl #(
    .WORD_W        (WORD_W),
    .FRAME_PATTERN (FRAME_PATTERN),
    .LOCK_COUNT    (LOCK_COUNT),
    .SETTLE_WORDS  (SETTLE_WORDS)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .frameWord (frameWord),
    .wordValid (wordValid),
    .ctrl      (ctrl),
    .locked    (locked)
  );

endmodule

// File: tb/adc_frame_deser_tb.sv
module adc_frame_deser_tb_top;
  localparam int LANES  = 3;
  localparam int W      = 12;
  localparam int LOCKN  = 3;
  localparam int SETTLE = 2;
  localparam logic [W-1:0] PAT = 12'h03F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameIn = 1'b0;
  logic [LANES-1:0] dataIn = '0;
  logic [LANES-1:0][W-1:0] dataWords;
  logic [W-1:0] frameWord;
  logic wordValid;
  logic locked;

  always #10 clk = ~clk;

  adc_frame_deser #(
    .DATA_LANES   (LANES),
    .WORD_W       (W),
    .LOCK_COUNT   (LOCKN),
    .SETTLE_WORDS (SETTLE)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .frameIn   (frameIn),
    .dataIn    (dataIn),
    .dataWords (dataWords),
    .frameWord (frameWord),
    .wordValid (wordValid),
    .locked    (locked)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [LANES*W-1:0] expQ[$];
  int phase = 0;
  int pendShift = 0;
  bit injected = 0;
  bit driveOn = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] dataWordOf(input int f, input int l);
    return W'(f * 53 + l * 409 + 7);
  endfunction

  // Driver: even bits before a rising edge, odd bits before a falling edge.
  initial begin
    int bitIdx = 0;
    forever begin
      if (bitIdx % 2 == 0) @(negedge clk); else @(posedge clk);
      #5;
      if (driveOn) begin
        int pos;
        int fr;
        logic [W-1:0] dw;
        logic [LANES*W-1:0] expv;
        pos = (bitIdx + phase) % W;
        fr  = (bitIdx + phase) / W;
        frameIn = PAT[W-1-pos];
        for (int l = 0; l < LANES; l++) begin
          dw = dataWordOf(fr, l);
          dataIn[l] = dw[W-1-pos];
          expv[l*W +: W] = dw;
        end
        if (pos == W - 1) begin
          expQ.push_back(expv);
          if (pendShift != 0) begin
            phase += pendShift;
            pendShift = 0;
            injected = 1;
          end
        end
        bitIdx++;
      end
    end
  end

  // Monitor / scoreboard.
  initial begin
    bit synced = 0;
    bit prevLocked = 0;
    bit missPend = 0;
    int run = 0;
    int gapCnt = 0;
    int chgSeen = 0;
    int sinceValid = 0;
    int validSeen = 0;
    logic [W-1:0] lastFrame = '0;
    logic [LANES*W-1:0] got;
    forever begin
      @(posedge clk); #3;
      if (rst) begin
        synced = 0; prevLocked = 0; missPend = 0; run = 0;
        chgSeen = 0; gapCnt = 0; sinceValid = 0; validSeen = 0; lastFrame = '0;
        continue;
      end
      sinceValid++;
      if (missPend) begin
        check(!locked, "R6 unlock after miss", 64'(locked), 64'd0);
        missPend = 0;
      end
      if (locked && !prevLocked)
        check(run >= LOCKN, "R5 lock needs consecutive hits", 64'(run), 64'(LOCKN));
      if (wordValid) begin
        if (validSeen > 0)
          check(sinceValid == W / 2, "R1 valid period", 64'(sinceValid), 64'(W / 2));
        validSeen++;
        sinceValid = 0;
        run = (frameWord == PAT) ? run + 1 : 0;
        if (injected) begin chgSeen = 0; injected = 0; end
        gapCnt++;
        if (frameWord != lastFrame) begin
          chgSeen++;
          if (chgSeen >= 3 && !locked)
            check(gapCnt >= SETTLE + 1, "R9 settle between slips", 64'(gapCnt), 64'(SETTLE + 1));
          gapCnt = 0;
          lastFrame = frameWord;
        end
        got = dataWords;
        if (locked && frameWord != PAT) begin
          missPend = 1;
          synced = 0;
        end else if (locked) begin
          if (!synced) begin
            while (expQ.size() > 0 && expQ[0] != got) void'(expQ.pop_front());
            check(expQ.size() > 0, "R4 lanes aligned together", 64'(got), 64'(0));
            if (expQ.size() > 0) begin
              void'(expQ.pop_front());
              synced = 1;
            end
          end else if (expQ.size() == 0) begin
            check(0, "R2 word with no frame sent", 64'(got), 64'(0));
          end else begin
            logic [LANES*W-1:0] e;
            e = expQ.pop_front();
            check(got == e, "R2 data word", 64'(got), 64'(e));
          end
        end
      end
      prevLocked = locked;
    end
  end

  task automatic waitLock(input string req);
    int n = 0;
    while (!locked && n < 300) begin @(posedge clk); #3; n++; end
    check(locked, req, 64'(locked), 64'd1);
  endtask

  task automatic waitUnlock();
    int n = 0;
    while (locked && n < 40) begin @(posedge clk); #3; n++; end
    check(!locked, "R6 shift detected", 64'(locked), 64'd0);
  endtask

  task automatic holdLocked(input int words);
    for (int k = 0; k < words; k++) begin
      do begin @(posedge clk); #3; end while (!wordValid);
      check(frameWord == PAT, "R3 frame word while locked", 64'(frameWord), 64'(PAT));
      check(locked, "R3 lock held", 64'(locked), 64'd1);
    end
  endtask

  task automatic shiftAndRelock(input int amount, input string req);
    pendShift = amount;
    waitUnlock();
    waitLock(req);
    holdLocked(8);
  endtask

  initial begin
    driveOn = 1;
    rst = 1;
    repeat (8) @(posedge clk);
    #3;
    check(!wordValid, "R8 no valid in reset", 64'(wordValid), 64'd0);
    check(!locked, "R8 unlocked in reset", 64'(locked), 64'd0);
    check(frameWord == '0, "R8 frame word cleared", 64'(frameWord), 64'd0);
    check(dataWords == '0, "R8 data words cleared", 64'(dataWords), 64'd0);
    @(posedge clk); #1 rst = 0;
    waitLock("R4 initial lock");
    holdLocked(10);
    shiftAndRelock(1, "R7 relock after +1 shift");
    shiftAndRelock(W - 1, "R7 relock after -1 shift (wrap)");
    shiftAndRelock(5, "R4 relock after 5-bit shift");
    shiftAndRelock(W - 1, "R7 relock second wrap");
    // Reset in the middle of a locked run.
    @(posedge clk); #1 rst = 1;
    repeat (2) @(posedge clk);
    #3;
    check(!locked, "R8 reset clears lock", 64'(locked), 64'd0);
    check(dataWords == '0, "R8 reset clears words", 64'(dataWords), 64'd0);
    check(frameWord == '0, "R8 reset clears frame word", 64'(frameWord), 64'd0);
    @(posedge clk); #1 rst = 0;
    waitLock("R4 lock after reset");
    holdLocked(6);
    finishRun();
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule